// File: doc/BRIEF.md
# Grouped Carry-Lookahead Adder

This block adds two unsigned operands and a carry input, producing a sum of the operand width and a carry output. The operand is split into 4-bit sections. Inside each section every column carry is formed directly from the per-bit generate and propagate terms and the section's carry input, so no carry passes from cell to cell. Only the carry leaving a section is chained into the section above it. This sits between a full lookahead tree and a plain ripple chain.

The adder core is purely combinational. For use in a clocked design, the top module captures the result in output registers, so a result appears one clock after its operands are presented. A synchronous active-high reset clears those registers. The width is a parameter and must be a multiple of four. The default width is 8, which gives two sections.

Top module: `grouped_cla_adder`

## Requirements
- R1: While `rst` is high at a rising clock edge, `sum` and `cout` become 0 at that edge.
- R2: At the rising edge after operands are sampled with `rst` low, `sum` equals (a + b + cin) modulo 2^WIDTH.
- R3: At the same edge, `cout` is 1 exactly when a + b + cin is 2^WIDTH or more. For example, 200 + 100 + 0 gives `sum` = 44 with `cout` = 1.
- R4: A carry produced in the low 4-bit section reaches the next section. For example, a = 0x0F, b = 0x00, cin = 1 gives `sum` = 0x10 with `cout` = 0.
- R5: When every bit position propagates (a | b is all ones) and cin = 1, `cout` is 1. For example, a = 0xFF, b = 0x00, cin = 1 gives `sum` = 0x00 with `cout` = 1.
- R6: With b = 0 and cin = 0, `sum` equals a and `cout` is 0.
- R7: For the 8-bit default, all 2^17 combinations of a, b and cin give {cout, sum} = a + b + cin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output registers |
| rst | input | 1 | Synchronous active-high reset of the output registers |
| a | input | WIDTH | First operand, unsigned |
| b | input | WIDTH | Second operand, unsigned |
| cin | input | 1 | Carry into the least significant column |
| sum | output | WIDTH | Registered sum, modulo 2^WIDTH |
| cout | output | 1 | Registered carry out of the top section |

## Verification
The checker tests on every clock edge the parts of the behaviour that can be stated from the previous cycle's operands:
- the reset clear,
- the modular sum,
- the carry-out written as an unsigned comparison of a against the complement of b,
- the all-propagate carry,
- the zero-operand identity.

The bench's directed vectors show the carry leaving the low section and reaching the high one, and the worst-case chain through every column. Its exhaustive sweep shows that no single input combination is mishandled, which no per-cycle property can show.

// File: rtl/cla_pkg.sv
package cla_pkg;
  localparam int GROUP_W = 4;

  function automatic int group_count(input int width);
    return width / GROUP_W;
  endfunction
endpackage

// File: rtl/cla_pg.sv
module cla_pg #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] gen,
  output logic [W-1:0] prop
);
  assign gen  = a & b;
  assign prop = a | b;
endmodule

// File: rtl/cla_carry.sv
module cla_carry #(
  parameter int W = 4
) (
  input  logic [W-1:0] gen,
  input  logic [W-1:0] prop,
  input  logic         cin,
  output logic [W:0]   carry
);
  // Each carry is a flat sum of products of g/p and cin; no term uses another carry.
  always_comb begin
    logic acc;
    logic term;
    carry[0] = cin;
    for (int i = 1; i <= W; i++) begin
      acc = 1'b0;
      for (int j = 0; j < i; j++) begin
        term = gen[j];
        for (int k = j + 1; k < i; k++) term = term & prop[k];
        acc = acc | term;
      end
      term = cin;
      for (int k = 0; k < i; k++) term = term & prop[k];
      carry[i] = acc | term;
    end
  end
endmodule

// File: rtl/cla_group.sv
module cla_group #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W-1:0] gen;
  logic [W-1:0] prop;
  logic [W:0]   carry;

  cla_pg #(.W(W)) pg_i (
    .a(a), .b(b), .gen(gen), .prop(prop)
  );

  cla_carry #(.W(W)) carry_i (
    .gen(gen), .prop(prop), .cin(cin), .carry(carry)
  );

  assign sum  = a ^ b ^ carry[W-1:0];
  assign cout = carry[W];
endmodule

// File: rtl/grouped_cla_adder.sv
module grouped_cla_adder
  import cla_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  localparam int NGRP = group_count(WIDTH);

  logic [NGRP:0]    chain;
  logic [WIDTH-1:0] sum_c;

  generate
    if (WIDTH % GROUP_W != 0 || WIDTH == 0) begin : g_bad_width
      $error("WIDTH must be a nonzero multiple of the section width");
    end
  endgenerate

  assign chain[0] = cin;

  for (genvar gi = 0; gi < NGRP; gi++) begin : g_sect
    cla_group #(.W(GROUP_W)) grp_i (
      .a   (a[gi*GROUP_W +: GROUP_W]),
      .b   (b[gi*GROUP_W +: GROUP_W]),
      .cin (chain[gi]),
      .sum (sum_c[gi*GROUP_W +: GROUP_W]),
      .cout(chain[gi+1])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum  <= '0;
      cout <= 1'b0;
    end else begin
      sum  <= sum_c;
      cout <= chain[NGRP];
    end
  end
endmodule

// File: rtl/grouped_cla_adder_chk.sv
module grouped_cla_adder_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] a,
  input logic [WIDTH-1:0] b,
  input logic             cin,
  input logic [WIDTH-1:0] sum,
  input logic             cout
);
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (sum == '0 && !cout)); // R1

  AST_SUM_MODULO: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> sum == WIDTH'($past(a) + $past(b) + WIDTH'($past(cin)))); // R2

  AST_CARRY_COMPARE: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> cout == (($past(a) > ~$past(b)) || (($past(a) == ~$past(b)) && $past(cin)))); // R3

  AST_ALL_PROPAGATE: assert property (@(posedge clk) disable iff (rst)
    (((a | b) == '1) && cin) |=> cout); // R5

  AST_ZERO_IDENTITY: assert property (@(posedge clk) disable iff (rst)
    ((b == '0) && !cin) |=> (sum == $past(a) && !cout)); // R6
endmodule

bind grouped_cla_adder grouped_cla_adder_chk #(.WIDTH(WIDTH)) chk_i (.*);

// File: tb/grouped_cla_adder_tb_top.sv
module grouped_cla_adder_tb_top;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst;
  logic [W-1:0] a;
  logic [W-1:0] b;
  logic         cin;
  logic [W-1:0] sum;
  logic         cout;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  grouped_cla_adder #(.WIDTH(W)) dut_i (
    .clk(clk), .rst(rst), .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout)
  );

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
    end
  endtask

  // Drive at a falling edge, the register captures at the next rising edge, sample at the falling edge after it.
  task automatic apply(input string req, input int av, input int bv, input int cv);
    int total;
    a   = av[W-1:0];
    b   = bv[W-1:0];
    cin = cv[0];
    total = av + bv + cv;
    @(negedge clk);
    check({req, " sum"}, int'(sum), total % (1 << W));
    check({req, " cout"}, int'(cout), (total >= (1 << W)) ? 1 : 0);
  endtask

  initial begin
    rst = 1'b1; a = '1; b = '1; cin = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset sum", int'(sum), 0);
    check("R1 reset cout", int'(cout), 0);
    rst = 1'b0;
    apply("R2 plain add", 23, 41, 0);
    apply("R3 overflow", 200, 100, 0);
    apply("R3 exact 2^W", 128, 127, 1);
    apply("R4 section carry", 8'h0F, 8'h00, 1);
    apply("R4 section carry gen", 8'h08, 8'h08, 0);
    apply("R5 full propagate", 8'hFF, 8'h00, 1);
    apply("R5 max operands", 8'hFF, 8'hFF, 1);
    apply("R6 zero identity", 8'hA5, 8'h00, 0);
    apply("R2 cin only", 0, 0, 1);
    // Assert reset mid-run: the outputs clear at the next edge
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid reset sum", int'(sum), 0);
    check("R1 mid reset cout", int'(cout), 0);
    rst = 1'b0;
    for (int ci = 0; ci < 2; ci++)
      for (int ai = 0; ai < (1 << W); ai++)
        for (int bi = 0; bi < (1 << W); bi++)
          apply("R7 exhaustive", ai, bi, ci);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule